// File: doc/BRIEF.md
# Two-Rail Overcurrent Hiccup Sequencer

This block is the digital fault sequencer for a regulator with two rails: a multiphase main rail and a single-phase auxiliary rail. Each rail supplies one averaged current word per clock. The block compares that word against a trip level. The level is 140 units while the rail is ramping in soft-start and 100 units once the rail is running. When the level is exceeded, the block turns that rail's gate drivers off and holds them off for a fixed wait. If the enable is still high at the end of the wait, it asks the rail to soft-start again.

Each rail counts the trips that occur without a completed soft-start in between. Once the final retry has failed, both rails are latched off, and only a reset releases them. A completed soft-start clears the count. A fault that exceeds only the running level therefore cycles through trip and retry without end.

The wait is built from a clock-enable tick. The tick period (TICK_DIV clocks) and the number of ticks (WAIT_TICKS) are parameters: with the real clock they give the 12 ms wait, and in simulation they give a short one. The defaults give 48 clocks.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset, both rails are in soft-start: main_drv_en, aux_drv_en, main_ss_req and aux_ss_req are 1, and extra_hiz and pgood_force_low are 0.
- R2: While a rail is in soft-start, its trip level is 140. A sample of 140 does not trip the rail. A sample of 141 or more turns its drv_en off on the clock edge that samples it.
- R3: A rail in soft-start whose ss_done input is 1 at a clock edge enters run on that edge, and its ss_req drops to 0 there. From that edge on, the trip level is 100: a sample of 100 does not trip the rail, and 101 trips it on the edge that samples it.
- R4: A main-rail trip sets main_drv_en to 0 and sets extra_hiz and pgood_force_low to 1 on the same edge. The auxiliary outputs are unaffected.
- R5: After a trip, the rail stays off for exactly WAIT_TICKS*TICK_DIV clocks (48 with the defaults), and its current samples and ss_done are ignored during that time. If en is 1, the rail then returns to soft-start, with drv_en and ss_req both 1.
- R6: If en is 0 when the wait ends, the rail stays off. It re-enters soft-start on the first clock edge that samples en as 1.
- R7: Each trip that is not preceded by a completed soft-start increments the rail's retry count, up to MAX_RETRY (7). With a fault present at every start, the first seven trips are each followed by a retry. The eighth trip latches the block.
- R8: Completing a soft-start clears the retry count. A fault that exceeds 100 but stays at or below 140 therefore never latches the block, however many cycles it causes.
- R9: An auxiliary-rail trip sets only aux_drv_en and aux_ss_req to 0. main_drv_en, main_ss_req, extra_hiz and pgood_force_low are unaffected.
- R10: Once latched (after a final trip on either rail), both drv_en outputs and both ss_req outputs are 0, and extra_hiz and pgood_force_low are 1, within two clock edges. This holds regardless of en, the samples or ss_done, until reset.
- R11: A trip sample and ss_done on the same edge during soft-start count as a trip: the rail turns off and does not enter run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en | input | 1 | Controller enable; gates the restart after a wait |
| main_cur | input | CUR_W | Averaged current sample of the main rail |
| aux_cur | input | CUR_W | Current sample of the auxiliary rail |
| main_ss_done | input | 1 | Main rail soft-start complete |
| aux_ss_done | input | 1 | Auxiliary rail soft-start complete |
| main_drv_en | output | 1 | Main-rail gate drivers enabled |
| aux_drv_en | output | 1 | Auxiliary-rail gate drivers enabled |
| extra_hiz | output | 1 | Request high impedance on the extra main phases |
| pgood_force_low | output | 1 | Force the power-good indication low |
| main_ss_req | output | 1 | Main-rail soft-start request |
| aux_ss_req | output | 1 | Auxiliary-rail soft-start request |

## Verification
A stale threshold select shows within one clock of leaving soft-start: a sample between 101 and 140 either trips the rail when it should not, or fails to trip it when it should, and drv_en shows the difference on the next edge. An error in the retry count shows only at the eighth consecutive trip. The latch then comes one retry too early or too late, or the block cycles forever, and both rails' drivers show this within two edges. A fault in the wait timer shows as a wrong number of clocks with drv_en low, which the bench counts exactly.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

    localparam int NUM_RAILS = 2;
    localparam int RAIL_MAIN = 0;
    localparam int RAIL_AUX  = 1;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SOFT  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LATCH = 2'd3
    } rail_st_e;

    typedef struct packed {
        logic drv_en;
        logic ss_req;
        logic off;
        logic latch_req;
    } rail_out_t;

    function automatic logic rail_live(input rail_st_e st);
        return (st == ST_SOFT) || (st == ST_RUN);
    endfunction

    function automatic int cnt_width(input int max_val);
        return (max_val > 1) ? $clog2(max_val + 1) : 1;
    endfunction

endpackage

// File: rtl/ocp_wait_timer.sv
module ocp_wait_timer #(
    parameter int TICK_DIV   = 4,
    parameter int WAIT_TICKS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    import ocp_hiccup_pkg::*;

    localparam int PW = cnt_width(TICK_DIV - 1);
    localparam int TW = cnt_width(WAIT_TICKS - 1);
    localparam logic [PW-1:0] P_MAX = PW'(TICK_DIV - 1);
    localparam logic [TW-1:0] T_MAX = TW'(WAIT_TICKS - 1);

    logic [PW-1:0] presc;
    logic [TW-1:0] ticks;
    logic          tick;

    assign tick = (presc == P_MAX);
    assign done = run && tick && (ticks == T_MAX);

    // counters saturate once done so the wait end stays visible while disabled
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            presc <= '0;
            ticks <= '0;
        end else if (!done) begin
            if (tick) begin
                presc <= '0;
                ticks <= ticks + 1'b1;
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ocp_rail_seq.sv
module ocp_rail_seq #(
    parameter int CUR_W      = 8,
    parameter int NOM_LVL    = 100,
    parameter int SS_LVL     = 140,
    parameter int TICK_DIV   = 4,
    parameter int WAIT_TICKS = 12,
    parameter int MAX_RETRY  = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [CUR_W-1:0]          cur,
    input  logic                      ss_done,
    input  logic                      latch_all,
    output ocp_hiccup_pkg::rail_out_t ro
);
    import ocp_hiccup_pkg::*;

    localparam int CNT_W = cnt_width(MAX_RETRY);
    localparam logic [CUR_W-1:0] LVL_NOM = CUR_W'(NOM_LVL);
    localparam logic [CUR_W-1:0] LVL_SS  = CUR_W'(SS_LVL);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RETRY);

    rail_st_e         st, st_nx;
    logic [CNT_W-1:0] fails, fails_nx;
    logic             thr_hi;
    logic             over;
    logic             trip;
    logic             final_trip;
    logic             wait_done;

    assign over = cur > (thr_hi ? LVL_SS : LVL_NOM);
    assign trip = rail_live(st) && over;

    ocp_wait_timer #(
        .TICK_DIV  (TICK_DIV),
        .WAIT_TICKS(WAIT_TICKS)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .run (st == ST_WAIT),
        .done(wait_done)
    );

    always_comb begin
        st_nx      = st;
        fails_nx   = fails;
        final_trip = 1'b0;
        if (latch_all) begin
            st_nx = ST_LATCH;
        end else if (trip) begin
            // trip wins over a simultaneous soft-start completion
            if (fails == CNT_MAX) begin
                final_trip = 1'b1;
                st_nx      = ST_LATCH;
            end else begin
                fails_nx = fails + 1'b1;
                st_nx    = ST_WAIT;
            end
        end else begin
            unique case (st)
                ST_SOFT: if (ss_done) begin
                    st_nx    = ST_RUN;
                    fails_nx = '0;
                end
                ST_WAIT: if (wait_done && en) st_nx = ST_SOFT;
                default: st_nx = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_SOFT;
            fails  <= '0;
            thr_hi <= 1'b1;
        end else begin
            st     <= st_nx;
            fails  <= fails_nx;
            thr_hi <= (st_nx == ST_SOFT);
        end
    end

    always_comb begin
        ro.drv_en    = rail_live(st);
        ro.ss_req    = (st == ST_SOFT);
        ro.off       = !rail_live(st);
        ro.latch_req = final_trip;
    end

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
    parameter int CUR_W      = 8,
    parameter int NOM_LVL    = 100,
    parameter int SS_LVL     = 140,
    parameter int TICK_DIV   = 4,
    parameter int WAIT_TICKS = 12,
    parameter int MAX_RETRY  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CUR_W-1:0] main_cur,
    input  logic [CUR_W-1:0] aux_cur,
    input  logic             main_ss_done,
    input  logic             aux_ss_done,
    output logic             main_drv_en,
    output logic             aux_drv_en,
    output logic             extra_hiz,
    output logic             pgood_force_low,
    output logic             main_ss_req,
    output logic             aux_ss_req
);
    import ocp_hiccup_pkg::*;

    logic [CUR_W-1:0] cur_arr  [NUM_RAILS];
    logic             done_arr [NUM_RAILS];
    rail_out_t        rout     [NUM_RAILS];
    logic             latch_q;
    logic             any_req;

    assign cur_arr[RAIL_MAIN]  = main_cur;
    assign cur_arr[RAIL_AUX]   = aux_cur;
    assign done_arr[RAIL_MAIN] = main_ss_done;
    assign done_arr[RAIL_AUX]  = aux_ss_done;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        ocp_rail_seq #(
            .CUR_W     (CUR_W),
            .NOM_LVL   (NOM_LVL),
            .SS_LVL    (SS_LVL),
            .TICK_DIV  (TICK_DIV),
            .WAIT_TICKS(WAIT_TICKS),
            .MAX_RETRY (MAX_RETRY)
        ) u_seq (
            .clk      (clk),
            .rst      (rst),
            .en       (en),
            .cur      (cur_arr[g]),
            .ss_done  (done_arr[g]),
            .latch_all(latch_q),
            .ro       (rout[g])
        );
    end

    always_comb begin
        any_req = 1'b0;
        for (int i = 0; i < NUM_RAILS; i++) any_req = any_req | rout[i].latch_req;
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= 1'b0;
        else     latch_q <= latch_q | any_req;
    end

    assign main_drv_en     = rout[RAIL_MAIN].drv_en;
    assign aux_drv_en      = rout[RAIL_AUX].drv_en;
    assign main_ss_req     = rout[RAIL_MAIN].ss_req;
    assign aux_ss_req      = rout[RAIL_AUX].ss_req;
    assign extra_hiz       = rout[RAIL_MAIN].off;
    assign pgood_force_low = rout[RAIL_MAIN].off;

endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic main_ss_done,
    input logic aux_ss_done,
    input logic main_drv_en,
    input logic aux_drv_en,
    input logic main_ss_req,
    input logic aux_ss_req,
    input logic latch_q
);

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
        latch_q |=> latch_q); // R10

    AST_LATCH_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        latch_q |=> (!main_drv_en && !aux_drv_en && !main_ss_req && !aux_ss_req)); // R10

    AST_MAIN_WAKE_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(main_drv_en) |-> $past(en)); // R6

    AST_AUX_WAKE_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(aux_drv_en) |-> $past(en)); // R6

    AST_MAIN_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(main_drv_en) |=> !main_drv_en); // R5

    AST_MAIN_RUN_DONE: assert property (@(posedge clk) disable iff (rst)
        ($fell(main_ss_req) && main_drv_en) |-> $past(main_ss_done)); // R3

    AST_AUX_RUN_DONE: assert property (@(posedge clk) disable iff (rst)
        ($fell(aux_ss_req) && aux_drv_en) |-> $past(aux_ss_done)); // R3

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .main_ss_done(main_ss_done),
    .aux_ss_done (aux_ss_done),
    .main_drv_en (main_drv_en),
    .aux_drv_en  (aux_drv_en),
    .main_ss_req (main_ss_req),
    .aux_ss_req  (aux_ss_req),
    .latch_q     (latch_q)
);

// File: tb/ocp_hiccup_ctrl_test.sv
module ocp_hiccup_ctrl_test;

    localparam int WAIT_CLKS = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic [7:0] main_cur = '0;
    logic [7:0] aux_cur  = '0;
    logic       main_ss_done = 1'b0;
    logic       aux_ss_done  = 1'b0;
    logic       main_drv_en, aux_drv_en, extra_hiz, pgood_force_low;
    logic       main_ss_req, aux_ss_req;

    int tests  = 0;
    int fails  = 0;
    bit ending = 1'b0;

    always #10 clk = ~clk;

    ocp_hiccup_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .main_cur       (main_cur),
        .aux_cur        (aux_cur),
        .main_ss_done   (main_ss_done),
        .aux_ss_done    (aux_ss_done),
        .main_drv_en    (main_drv_en),
        .aux_drv_en     (aux_drv_en),
        .extra_hiz      (extra_hiz),
        .pgood_force_low(pgood_force_low),
        .main_ss_req    (main_ss_req),
        .aux_ss_req     (aux_ss_req)
    );

    typedef struct packed {
        logic [7:0] mc;
        logic [7:0] ac;
        logic       mdone;
        logic       adone;
        logic [3:0] req;
        logic       e_md;
        logic       e_ad;
        logic       e_ms;
        logic       e_as;
        logic       e_off;
    } vec_t;

    // one clock per entry, starting right after reset; expected values after that edge
    localparam vec_t VECS [6] = '{
        '{8'd140, 8'd140, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 no trip at 140
        '{8'd140, 8'd0,   1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 main enters run
        '{8'd100, 8'd0,   1'b0, 1'b0, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 no trip at 100
        '{8'd100, 8'd141, 1'b0, 1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 aux trip alone
        '{8'd101, 8'd0,   1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 main trip at 101
        '{8'd255, 8'd255, 1'b1, 1'b1, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R5 ignored while off
    };

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ending) begin
            ending = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b1;
        main_cur = '0; aux_cur = '0; main_ss_done = 1'b0; aux_ss_done = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic drv(input bit aux);
        return aux ? aux_drv_en : main_drv_en;
    endfunction

    // presents an overcurrent sample for one clock; returns at the next negedge
    task automatic trip_rail(input bit aux);
        if (aux) aux_cur = 8'd200; else main_cur = 8'd200;
        @(negedge clk);
        if (aux) aux_cur = '0; else main_cur = '0;
    endtask

    // counts sampled clocks with the rail off (first off sample already seen)
    task automatic wait_back(input bit aux, output int n);
        n = 1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (drv(aux)) break;
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int n;
        do_reset();

        // R1 reset state
        chk("R1 main_drv_en", main_drv_en, 1);
        chk("R1 aux_drv_en", aux_drv_en, 1);
        chk("R1 main_ss_req", main_ss_req, 1);
        chk("R1 aux_ss_req", aux_ss_req, 1);
        chk("R1 extra_hiz", extra_hiz, 0);
        chk("R1 pgood_force_low", pgood_force_low, 0);

        foreach (VECS[i]) begin
            main_cur = VECS[i].mc; aux_cur = VECS[i].ac;
            main_ss_done = VECS[i].mdone; aux_ss_done = VECS[i].adone;
            @(negedge clk);
            chk($sformatf("R%0d step%0d main_drv_en", VECS[i].req, i), main_drv_en, VECS[i].e_md);
            chk($sformatf("R%0d step%0d aux_drv_en", VECS[i].req, i), aux_drv_en, VECS[i].e_ad);
            chk($sformatf("R%0d step%0d main_ss_req", VECS[i].req, i), main_ss_req, VECS[i].e_ms);
            chk($sformatf("R%0d step%0d aux_ss_req", VECS[i].req, i), aux_ss_req, VECS[i].e_as);
            chk($sformatf("R%0d step%0d extra_hiz", VECS[i].req, i), extra_hiz, VECS[i].e_off);
            chk($sformatf("R%0d step%0d pgood_force_low", VECS[i].req, i), pgood_force_low, VECS[i].e_off);
        end
        main_cur = '0; aux_cur = '0; main_ss_done = 1'b0; aux_ss_done = 1'b0;

        // R5 exact wait length and restart
        do_reset();
        trip_rail(1'b0);
        chk("R4 main off", main_drv_en, 0);
        chk("R4 hiz", extra_hiz, 1);
        chk("R4 aux unaffected", aux_drv_en, 1);
        wait_back(1'b0, n);
        chk("R5 wait clocks", n, WAIT_CLKS);
        chk("R5 ss_req after wait", main_ss_req, 1);
        chk("R5 hiz released", extra_hiz, 0);

        // R6 enable low at end of wait
        do_reset();
        trip_rail(1'b0);
        en = 1'b0;
        repeat (WAIT_CLKS + 20) @(negedge clk);
        chk("R6 held off", main_drv_en, 0);
        chk("R6 no request", main_ss_req, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R6 restart", main_ss_req, 1);

        // R11 trip beats soft-start done
        do_reset();
        main_cur = 8'd150; main_ss_done = 1'b1;
        @(negedge clk);
        main_cur = '0; main_ss_done = 1'b0;
        chk("R11 off", main_drv_en, 0);
        chk("R11 not run", main_ss_req, 0);

        // R7 seven retries then latch (main)
        do_reset();
        for (int t = 1; t <= 7; t++) begin
            trip_rail(1'b0);
            wait_back(1'b0, n);
            chk($sformatf("R7 retry %0d wait", t), n, WAIT_CLKS);
        end
        chk("R7 still retrying", main_ss_req, 1);
        trip_rail(1'b0);
        chk("R7 main off at final trip", main_drv_en, 0);
        @(negedge clk);
        chk("R10 aux off after latch", aux_drv_en, 0);
        chk("R10 aux ss_req", aux_ss_req, 0);
        for (int k = 0; k < 120; k++) begin
            en = k[3]; main_ss_done = k[0]; aux_ss_done = k[1];
            @(negedge clk);
        end
        main_ss_done = 1'b0; aux_ss_done = 1'b0; en = 1'b1;
        @(negedge clk);
        chk("R10 main stays off", main_drv_en, 0);
        chk("R10 main no request", main_ss_req, 0);
        chk("R10 pgood forced", pgood_force_low, 1);
        do_reset();
        chk("R10 reset releases", main_drv_en & aux_drv_en, 1);

        // R8 nominal-only fault hiccups forever
        do_reset();
        main_cur = 8'd120;
        for (int t = 0; t < 10; t++) begin
            main_ss_done = 1'b1;
            @(negedge clk);
            main_ss_done = 1'b0;
            chk("R3 run entered", main_ss_req, 0);
            @(negedge clk);
            chk("R8 trip at 120 in run", main_drv_en, 0);
            wait_back(1'b0, n);
            chk("R8 retry not latched", main_drv_en, 1);
        end
        main_cur = '0;

        // R9/R10 aux retries, then latch takes main too
        do_reset();
        for (int t = 1; t <= 7; t++) begin
            trip_rail(1'b1);
            chk("R9 main unaffected", main_drv_en, 1);
            chk("R9 hiz unaffected", extra_hiz, 0);
            wait_back(1'b1, n);
        end
        trip_rail(1'b1);
        chk("R10 aux off at final", aux_drv_en, 0);
        @(negedge clk);
        chk("R10 main latched by aux", main_drv_en, 0);
        chk("R10 hiz after aux latch", extra_hiz, 1);
        repeat (WAIT_CLKS * 2) @(negedge clk);
        chk("R10 aux stays off", aux_drv_en | main_drv_en, 0);

        finish_run();
    end

endmodule